// File: doc/BRIEF.md
# EDID Register Read Controller

This block answers display-identification reads from a host without driving any real serial bus. The host sees four 32-bit registers: a pin selector, a command word, a status word and a data window. The host picks a display port through the pin selector and then issues a command. The command carries a target address, a byte count, an optional start offset and a bus cycle type. The host then polls status and reads the data window, which returns up to four identification bytes packed per access. Every byte comes from a local store that holds 128 bytes per port. That store is filled through a side write port that is not part of the register map.

Two input vectors describe each port: one says whether a monitor is attached, the other whether the port is DisplayPort. Identification data is served only for an attached monitor on a port that is not DisplayPort. Any other selection raises the error status bit. Phase tracking follows the cycle type, and the phase is visible in the status word.

Register map (`regAddr`): 0 is pin select, 1 is command, 2 is status, 3 is data. Read data is combinational during the cycle `regRdEn` is high. Side effects take place at the clock edge that ends the access. When a write and a read are requested in the same cycle, the write wins and the read has no side effect.

Top module: `edid_regctl`

## Requirements
- R1: After reset, all four registers read as zero.
- R2: A pin-select write stores the word and clears transfer state (slave selection, availability, read pointer, byte count, stored cycle) and sets the phase to idle. Pin values 1..NPORTS (bits 2:0) select ports 0..NPORTS-1. A value of 0 or above NPORTS does nothing further. A valid value clears active (status bit 2) and sets ready (bit 0) and wait (bit 3). It sets the error bit (bit 1) unless that port has a monitor and is not DisplayPort, in which case it clears the error bit and marks the data available.
- R3: On a command write applied while command bit 31 is stored as 0, the following hold. Address bits 7:1 equal to 0x50 select the slave. Bits 24:16 load the byte count. Bit 26 set loads the read pointer from bits 15:8. The command is stored with bit 30 forced to 0, and bit 0 set means read direction.
- R4: Cycle field bits 27:25 with values 1, 3, 5 or 7 set the phase to data (status bits 7:6 = 01) and set active.
- R5: Cycle value 4 (stop) takes effect only if the stored cycle field is nonzero. It then clears transfer state, sets the phase to idle and clears active. Otherwise it changes neither phase nor active.
- R6: A command write with bit 31 set, made while bit 31 is stored as 0, sets ready. While bit 31 is stored, a write with bit 31 = 0 clears only the stored bit 31 and applies no other field. It also resets status to ready plus the error bit (error set if no data is available), clears in-use, and sets the phase to idle. A write that keeps bit 31 = 1 has no effect.
- R7: A data read with read direction set returns min(4, count - pointer) bytes, little-endian from the pointer. Lanes not filled keep their previous value. If nothing remains, or read direction is clear, the previous data word is returned and nothing advances.
- R8: A data read that takes the last four or fewer bytes sets the phase to idle for cycle values 5 and 7 and to wait (10) otherwise, and it clears transfer state.
- R9: A byte returns 0 and does not advance the pointer when no slave is selected, the pointer is 128 or more, or no data is available.
- R10: A status read returns the old value and then sets in-use (bit 5). A status write with bit 5 set clears in-use, and the other bits ignore status writes.
- R11: Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid while regRdEn is high |
| monPresent | input | NPORTS | Monitor attached, per port |
| portIsDp | input | NPORTS | Port is DisplayPort, per port |
| edidWrEn | input | 1 | Store write strobe |
| edidWrPort | input | PORT_W | Store write port |
| edidWrAddr | input | 7 | Store write byte offset |
| edidWrByte | input | 8 | Store write byte |

## Verification
Reads are run with several command shapes, and each one isolates a different part of the block. A plain stop-type read of ten bytes shows the lane packing and the kept upper lanes on the short tail. An indexed wait-type read that starts at offset 126 runs past the end of the store and shows the zero bytes and the wait phase. Selecting a DisplayPort port, an empty port, an unmapped pin and a foreign slave address each makes the data source invalid in a different way. Stop cycles issued with and without a pending cycle, entry to and exit from the clear-interrupt state, and status in-use toggling each exercise one control path.

// File: rtl/edid_regctl_pkg.sv
`timescale 1ns/1ps
package edid_regctl_pkg;
  localparam int EDID_BYTES = 128;
  localparam logic [6:0] EDID_SLAVE = 7'h50;

  localparam logic [1:0] REG_PIN  = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam logic [2:0] CYC_NONE = 3'd0;
  localparam logic [2:0] CYC_STOP = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrXfer;
    logic ldCount;
    logic ldPtr;
    logic dataRd;
    logic srcOk;
  } dpStrobe_t;
endpackage

// File: rtl/edid_regctl_dp.sv
`timescale 1ns/1ps
module edid_regctl_dp
  import edid_regctl_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [PORT_W-1:0] portSel,
  input  logic [8:0]        cmdCount,
  input  logic [7:0]        cmdIndex,
  input  logic              edidWrEn,
  input  logic [PORT_W-1:0] edidWrPort,
  input  logic [6:0]        edidWrAddr,
  input  logic [7:0]        edidWrByte,
  output logic              lastChunk,
  output logic [31:0]       dataWord
);
  localparam int MEM_D = 1 << (PORT_W + 7);
  localparam int LANES = 4;

  logic [7:0]  store [MEM_D];
  logic [7:0]  rdPtr;
  logic [8:0]  byteCount;
  logic [31:0] dataReg;
  logic [9:0]  remain;
  logic        remPos;
  logic [2:0]  nTake;
  logic [LANES-1:0] laneTake, laneOk;
  logic [31:0] packedWord;
  logic [2:0]  advance;

  always_ff @(posedge clk) begin
    if (edidWrEn) store[{edidWrPort, edidWrAddr}] <= edidWrByte;
  end

  assign remain    = {1'b0, byteCount} - {2'b00, rdPtr};
  assign remPos    = !remain[9] && (remain != 10'd0);
  assign lastChunk = remPos && (remain <= 10'd4);
  assign nTake     = lastChunk ? remain[2:0] : 3'd4;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] lanePtr;
    assign lanePtr     = {1'b0, rdPtr} + 9'(i);
    assign laneTake[i] = 3'(i) < nTake;
    assign laneOk[i]   = stb.srcOk && (lanePtr[8:7] == 2'b00);
    assign packedWord[8*i +: 8] = !laneTake[i] ? dataReg[8*i +: 8] :
                                  laneOk[i] ? store[{portSel, lanePtr[6:0]}] : 8'h00;
  end

  always_comb begin
    advance = 3'd0;
    for (int i = 0; i < LANES; i++)
      if (laneTake[i] && laneOk[i]) advance = advance + 3'd1;
  end

  assign dataWord = (stb.dataRd && remPos) ? packedWord : dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      byteCount <= '0;
      dataReg   <= '0;
    end else begin
      if (stb.dataRd && remPos) begin
        dataReg <= packedWord;
        rdPtr   <= rdPtr + 8'(advance);
      end
      if (stb.ldCount) byteCount <= cmdCount;
      if (stb.ldPtr)   rdPtr     <= cmdIndex;
      if (stb.clrXfer) begin
        rdPtr     <= '0;
        byteCount <= '0;
      end
    end
  end
endmodule

// File: rtl/edid_regctl_ctrl.sv
`timescale 1ns/1ps
module edid_regctl_ctrl
  import edid_regctl_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic [NPORTS-1:0] monPresent,
  input  logic [NPORTS-1:0] portIsDp,
  input  logic              lastChunk,
  input  logic [31:0]       dataWord,
  output logic [31:0]       regRdData,
  output dpStrobe_t         stb,
  output logic [PORT_W-1:0] portSel,
  output logic [31:0]       statusWord,
  output logic [31:0]       cmdWord
);
  logic [31:0] pinReg, cmdReg;
  logic ready, errBit, active, waitBit, inUse;
  logic slaveSel, edidAvail;
  logic [2:0] cycReg;
  phase_t phase;

  logic wrPin, wrCmd, wrStat, rdStat, rdDat;
  logic [2:0] pinVal, newCyc;
  logic pinMapped, monOk, applyCmd, leaveClr, stopOk, lastRead;
  logic [PORT_W-1:0] pinPort;

  assign wrPin  = regWrEn && regAddr == REG_PIN;
  assign wrCmd  = regWrEn && regAddr == REG_CMD;
  assign wrStat = regWrEn && regAddr == REG_STAT;
  assign rdStat = regRdEn && !regWrEn && regAddr == REG_STAT;
  assign rdDat  = regRdEn && !regWrEn && regAddr == REG_DATA;

  assign pinVal    = regWrData[2:0];
  assign pinMapped = pinVal != 3'd0 && 32'(pinVal) <= NPORTS;
  assign pinPort   = PORT_W'(pinVal - 3'd1);
  assign monOk     = monPresent[pinPort] && !portIsDp[pinPort];

  assign newCyc   = regWrData[27:25];
  assign applyCmd = wrCmd && !cmdReg[31];
  assign leaveClr = wrCmd && cmdReg[31] && !regWrData[31];
  assign stopOk   = applyCmd && newCyc == CYC_STOP && cmdReg[27:25] != CYC_NONE;
  assign lastRead = rdDat && cmdReg[0] && lastChunk;

  assign stb.clrXfer = wrPin || stopOk || lastRead;
  assign stb.ldCount = applyCmd;
  assign stb.ldPtr   = applyCmd && newCyc[1];
  assign stb.dataRd  = rdDat && cmdReg[0];
  assign stb.srcOk   = slaveSel && edidAvail;

  assign statusWord = {24'h0, phase, inUse, 1'b0, waitBit, active, errBit, ready};
  assign cmdWord    = cmdReg;

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        REG_PIN:  regRdData = pinReg;
        REG_CMD:  regRdData = cmdReg;
        REG_STAT: regRdData = statusWord;
        default:  regRdData = dataWord;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinReg <= '0; cmdReg <= '0;
      ready <= 1'b0; errBit <= 1'b0; active <= 1'b0; waitBit <= 1'b0; inUse <= 1'b0;
      slaveSel <= 1'b0; edidAvail <= 1'b0; cycReg <= '0; portSel <= '0;
      phase <= PH_IDLE;
    end else begin
      if (wrPin) begin
        pinReg <= regWrData;
        slaveSel <= 1'b0; edidAvail <= 1'b0; cycReg <= '0;
        phase <= PH_IDLE;
        if (pinMapped) begin
          ready <= 1'b1; waitBit <= 1'b1; active <= 1'b0;
          if (monOk) begin
            edidAvail <= 1'b1;
            portSel   <= pinPort;
            errBit    <= 1'b0;
          end else begin
            errBit <= 1'b1;
          end
        end
      end
      if (leaveClr) begin
        cmdReg[31] <= 1'b0;
        ready <= 1'b1; errBit <= !edidAvail;
        active <= 1'b0; waitBit <= 1'b0; inUse <= 1'b0;
        phase <= PH_IDLE;
      end
      if (applyCmd) begin
        if (regWrData[31]) ready <= 1'b1;
        if (regWrData[7:1] == EDID_SLAVE) slaveSel <= 1'b1;
        cycReg <= newCyc;
        cmdReg <= regWrData & ~32'h4000_0000;
        if (newCyc[0]) begin
          phase  <= PH_DATA;
          active <= 1'b1;
        end
        if (stopOk) begin
          slaveSel <= 1'b0; edidAvail <= 1'b0; cycReg <= '0;
          phase <= PH_IDLE;
          active <= 1'b0;
        end
      end
      if (wrStat && regWrData[5]) inUse <= 1'b0;
      if (rdStat) inUse <= 1'b1;
      if (lastRead) begin
        phase <= (cycReg == 3'd5 || cycReg == 3'd7) ? PH_IDLE : PH_WAIT;
        slaveSel <= 1'b0; edidAvail <= 1'b0; cycReg <= '0;
      end
    end
  end
endmodule

// File: rtl/edid_regctl.sv
`timescale 1ns/1ps
module edid_regctl
  import edid_regctl_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [NPORTS-1:0] monPresent,
  input  logic [NPORTS-1:0] portIsDp,
  input  logic              edidWrEn,
  input  logic [PORT_W-1:0] edidWrPort,
  input  logic [6:0]        edidWrAddr,
  input  logic [7:0]        edidWrByte
);
  dpStrobe_t         stb;
  logic [PORT_W-1:0] portSel;
  logic              lastChunk;
  logic [31:0]       dataWord, statusWord, cmdWord;

  edid_regctl_ctrl #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_ctrl (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData,
    .monPresent, .portIsDp, .lastChunk, .dataWord,
    .regRdData, .stb, .portSel, .statusWord, .cmdWord
  );

  edid_regctl_dp #(.PORT_W(PORT_W)) u_dp (
    .clk, .rstN, .stb, .portSel,
    .cmdCount(regWrData[24:16]), .cmdIndex(regWrData[15:8]),
    .edidWrEn, .edidWrPort, .edidWrAddr, .edidWrByte,
    .lastChunk, .dataWord
  );
endmodule

// File: rtl/edid_regctl_chk.sv
`timescale 1ns/1ps
module edid_regctl_chk #(
  parameter int NPORTS = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] statusWord,
  input logic [31:0] cmdWord
);
  // R2
  pin_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && regWrData[2:0] != 3'd0 && 32'(regWrData[2:0]) <= NPORTS)
    |=> (statusWord[0] && statusWord[3] && !statusWord[2] && statusWord[7:6] == 2'b00));
  // R3
  swrdy_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && !cmdWord[31]) |=> !cmdWord[30]);
  // R4
  data_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && !cmdWord[31] && regWrData[25])
    |=> (statusWord[2] && statusWord[7:6] == 2'b01));
  // R5
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && !cmdWord[31] && regWrData[27:25] == 3'd4 && cmdWord[27:25] != 3'd0)
    |=> (!statusWord[2] && statusWord[7:6] == 2'b00));
  // R6
  swclr_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && cmdWord[31] && !regWrData[31])
    |=> (!cmdWord[31] && statusWord[0] && !statusWord[2] && !statusWord[5]));
  // R10
  inuse_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == 2'd2) |=> statusWord[5]);
  // R10
  inuse_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2 && regWrData[5]) |=> !statusWord[5]);
endmodule

bind edid_regctl edid_regctl_chk #(.NPORTS(NPORTS)) chk (
  .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData, .statusWord, .cmdWord
);

// File: tb/edid_regctl_test.sv
`timescale 1ns/1ps
module edid_regctl_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [3:0] monPresent = 4'b1011, portIsDp = 4'b0010;
  logic edidWrEn = 1'b0;
  logic [1:0] edidWrPort = '0;
  logic [6:0] edidWrAddr = '0;
  logic [7:0] edidWrByte = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  edid_regctl #(.NPORTS(4)) uut (.*);

  // reference model
  logic [7:0] img [4][128];
  logic [31:0] mPin = 0, mCmd = 0, mData = 0;
  bit mReady, mErr, mAct, mWait, mInUse, mSel, mAvail;
  int mPhase = 0, mPort = 0, mPtr = 0, mCnt = 0, mCyc = 0;

  function automatic void mClear();
    mSel = 0; mAvail = 0; mPtr = 0; mCnt = 0; mCyc = 0; mPhase = 0;
  endfunction

  function automatic logic [31:0] mStatus();
    return {24'h0, 2'(mPhase), mInUse, 1'b0, mWait, mAct, mErr, mReady};
  endfunction

  function automatic logic [7:0] mByte();
    logic [7:0] b;
    if (!mSel || !mAvail || mPtr >= 128) return 8'h00;
    b = img[mPort][mPtr];
    mPtr++;
    return b;
  endfunction

  function automatic void mWrite(input int a, input logic [31:0] d);
    int p, cyc;
    case (a)
      0: begin
        mPin = d; mClear(); p = int'(d[2:0]);
        if (p != 0 && p <= 4) begin
          mReady = 1; mWait = 1; mAct = 0;
          if (monPresent[p-1] && !portIsDp[p-1]) begin mAvail = 1; mPort = p - 1; mErr = 0; end
          else mErr = 1;
        end
      end
      1: begin
        if (mCmd[31]) begin
          if (!d[31]) begin
            mCmd[31] = 0; mReady = 1; mErr = !mAvail; mAct = 0; mWait = 0; mInUse = 0; mPhase = 0;
          end
        end else begin
          cyc = int'(d[27:25]);
          if (d[31]) mReady = 1;
          mCnt = int'(d[24:16]);
          if (d[7:1] == 7'h50) mSel = 1;
          if (d[26]) mPtr = int'(d[15:8]);
          mCyc = cyc;
          if (cyc == 4 && mCmd[27:25] != 0) begin mClear(); mAct = 0; end
          else if (cyc % 2 == 1) begin mPhase = 1; mAct = 1; end
          mCmd = d & ~32'h4000_0000;
        end
      end
      2: if (d[5]) mInUse = 0;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] mRead(input int a);
    logic [31:0] r;
    int rem, n, ph;
    case (a)
      0: return mPin;
      1: return mCmd;
      2: begin r = mStatus(); mInUse = 1; return r; end
      default: begin
        if (!mCmd[0]) return mData;
        rem = mCnt - mPtr;
        if (rem <= 0) return mData;
        n = (rem > 4) ? 4 : rem;
        for (int i = 0; i < n; i++) mData[8*i +: 8] = mByte();
        if (rem <= 4) begin
          ph = (mCyc == 5 || mCyc == 7) ? 0 : 2;
          mClear(); mPhase = ph;
        end
        return mData;
      end
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(a); regWrData = d;
    mWrite(a, d);
    @(posedge clk); #0.5;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'(a);
    #1;
    exp = mRead(a);
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d got %h expected %h", tag, a, regRdData, exp);
    end
    @(posedge clk); #0.5;
    regRdEn = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input int cyc, input int cnt, input int idx,
                                      input int sa, input bit dirRd);
    return (32'(cyc) << 25) | (32'(cnt) << 16) | (32'(idx) << 8) | (32'(sa) << 1) | 32'(dirRd);
  endfunction

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 128; i++) img[p][i] = 8'h00;
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(a, "R1");
    // load store for ports 0 and 3
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      edidWrEn = 1'b1; edidWrPort = 2'd0; edidWrAddr = 7'(i); edidWrByte = 8'(i * 3 + 1);
      img[0][i] = 8'(i * 3 + 1);
      @(negedge clk);
      edidWrPort = 2'd3; edidWrByte = 8'(255 - i);
      img[3][i] = 8'(255 - i);
    end
    @(negedge clk); edidWrEn = 1'b0;

    // R2 valid non-DP port
    wr(0, 32'h1); rd(0, "R2"); rd(2, "R2");
    // R10 in-use set then cleared
    rd(2, "R10"); wr(2, 32'hFFFF_FFDF); rd(2, "R10"); wr(2, 32'h20); rd(2, "R10");
    // R3 R4 stop-type read of ten bytes, bit 30 forced low
    wr(1, cmd(5, 10, 0, 'h50, 1) | 32'h4000_0000); rd(1, "R3"); rd(2, "R4");
    // R7 packing and kept lanes; R8 idle after stop type
    rd(3, "R7"); rd(3, "R7"); rd(3, "R7"); rd(2, "R8");
    rd(3, "R7"); rd(2, "R8");
    // R9 R8 indexed wait-type read past the end of the store
    wr(0, 32'h4); wr(1, cmd(3, 130, 126, 'h50, 1)); rd(3, "R9"); rd(2, "R8");
    // R3 index without index flag does not move the pointer
    wr(0, 32'h4); wr(1, cmd(1, 6, 40, 'h50, 1)); rd(3, "R3"); rd(3, "R3");
    // R2 R9 DisplayPort port, empty port, unmapped pin
    wr(0, 32'h2); rd(2, "R2"); wr(1, cmd(1, 4, 0, 'h50, 1)); rd(3, "R9");
    wr(0, 32'h3); rd(2, "R2");
    wr(0, 32'h6); rd(0, "R2"); rd(2, "R2");
    // R9 foreign slave address
    wr(0, 32'h1); wr(1, cmd(1, 4, 0, 'h37, 1)); rd(3, "R9"); rd(2, "R4");
    // R5 stop without then with a pending cycle
    wr(0, 32'h1); wr(1, cmd(0, 0, 0, 0, 0)); wr(1, cmd(4, 0, 0, 0, 0)); rd(2, "R5");
    wr(1, cmd(1, 8, 0, 'h50, 1)); rd(2, "R5"); wr(1, cmd(4, 0, 0, 0, 0)); rd(2, "R5"); rd(1, "R5");
    // R6 clear-interrupt entry, hold and exit
    wr(0, 32'h1); rd(2, "R6");
    wr(1, 32'h8000_0000 | cmd(1, 8, 0, 'h50, 1)); rd(2, "R6"); rd(1, "R6");
    wr(1, 32'h8000_0000 | cmd(5, 3, 9, 'h11, 0)); rd(1, "R6"); rd(2, "R6");
    wr(1, cmd(7, 2, 5, 'h22, 0)); rd(1, "R6"); rd(2, "R6");
    // R7 direction clear returns previous word; R11 data write ignored
    rd(3, "R7"); wr(3, 32'hDEAD_BEEF); rd(3, "R11");
    wr(1, cmd(1, 2, 0, 'h50, 1)); wr(3, 32'h1234_5678); rd(3, "R11");
    rd(3, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule